// File: doc/BRIEF.md
# Block-Average Sample Rate Reducer

This block lowers the rate of a signed 14-bit sample stream by a factor taken from a small fixed set of powers of two. In pick mode it forwards the first sample of every block of N valid input samples. In mean mode it adds up each block of N samples and forwards their floor mean. Every forwarded sample comes with a single-cycle valid strobe, which the downstream acquisition logic uses.

The factor arrives as a 17-bit value together with a write strobe. Every write restarts block counting and empties the accumulator. Averaging is switched on by a separate level input. Because every legal factor is a power of two, the divide is a right shift by log2(N), and the divider holds no state.

Top module: `decim_rate_reducer`

## Requirements
- R1: While reset is active and after it is released, `out_valid_o` is 0 and `out_data_o` is 0 until a sample is emitted. The factor register resets to 1.
- R2: A cycle with `factor_wr_i` high loads the 17-bit `factor_i` into the factor register. The supported factors are 1, 8, 64, 1024, 8192 and 65536. Any other value leaves the output undefined.
- R3: With factor 1, each valid input sample appears on `out_data_o` with `out_valid_o` high in the next cycle, whatever the state of `avg_en_i`.
- R4: With `avg_en_i` low and factor N, the first valid sample of each block of N valid samples appears on the output one cycle after it is accepted. The other N-1 samples produce no output.
- R5: With `avg_en_i` high and factor N, the cycle after the Nth valid sample of a block carries floor(sum/N) of that block's N signed samples. The rounding goes toward minus infinity.
- R6: While the mode and the factor stay unchanged, exactly one output strobe occurs per block of N valid samples. `out_valid_o` is only ever high in the cycle after an accepted sample.
- R7: A cycle with `in_valid_i` low is ignored. It does not advance the block count, does not change the running sum and produces no output.
- R8: A factor write restarts the block count and clears the running sum. A sample presented in the same cycle as the write is discarded and produces no output.
- R9: The running sum does not overflow at the largest factor. 65536 samples of -8192 average to exactly -8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| factor_wr_i | input | 1 | Write strobe for the factor register |
| factor_i | input | 17 | New decimation factor |
| avg_en_i | input | 1 | 1 selects mean mode, 0 selects pick mode |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 14 | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 14 | Signed output sample |

## Verification
The ramp test runs at factor 8 in pick mode, and only the block-head samples may come out, so an off-by-one in the block count shows up at once. The mean tests at factors 8, 64 and 8192 mix the full-scale extremes with small negative sums. A small negative sum separates a floor mean from a truncating one. Gapped valid patterns and a factor write in the middle of a block check that idle cycles are ignored and that a restart really empties the sum. The run ends with a factor-65536 block at the negative full scale, which exposes any accumulator that is too narrow.

// File: rtl/decim_pkg.sv
package decim_pkg;

   typedef enum logic {
      MODE_PICK = 1'b0,
      MODE_MEAN = 1'b1
   } decim_mode_e;

   // Bit k set means factor 2**k is supported: 1, 8, 64, 1024, 8192, 65536
   localparam logic [16:0] DECIM_LEGAL_MASK_DEF = 17'h12449;

endpackage

// File: rtl/decim_factor_decode.sv
module decim_factor_decode #(
   parameter int unsigned FACTOR_W   = 17,
   parameter int unsigned CNT_W      = FACTOR_W - 1,
   parameter int unsigned SHIFT_W    = $clog2(FACTOR_W),
   parameter logic [FACTOR_W-1:0] LEGAL_MASK = '1
) (
   input  logic [FACTOR_W-1:0] factor_i,
   output logic [SHIFT_W-1:0]  shift_o,
   output logic [CNT_W-1:0]    last_idx_o,
   output logic                legal_o
);

   if (CNT_W != FACTOR_W - 1) begin : g_bad_cnt
      $error("CNT_W must be FACTOR_W-1");
   end
   if ((1 << SHIFT_W) < FACTOR_W) begin : g_bad_shift
      $error("SHIFT_W too narrow for FACTOR_W");
   end

   logic [FACTOR_W-1:0] hit;

   for (genvar k = 0; k < FACTOR_W; k++) begin : g_hit
      if (LEGAL_MASK[k]) begin : g_on
         assign hit[k] = (factor_i == (FACTOR_W'(1) << k));
      end else begin : g_off
         assign hit[k] = 1'b0;
      end
   end

   logic [FACTOR_W-1:0] span;

   always_comb begin
      shift_o = '0;
      for (int k = 0; k < FACTOR_W; k++) begin
         if (hit[k]) shift_o = SHIFT_W'(k);
      end
      legal_o    = |hit;
      span       = (FACTOR_W'(1) << shift_o) - FACTOR_W'(1);
      last_idx_o = span[CNT_W-1:0];
   end

endmodule

// File: rtl/decim_block_counter.sv
module decim_block_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] last_idx_i,
   output logic             first_o,
   output logic             final_o
);

   if (CNT_W < 1) begin : g_bad
      $error("CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (cnt_q >= last_idx_i) cnt_q <= '0;
         else                     cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign first_o = (cnt_q == '0);
   assign final_o = (cnt_q >= last_idx_i);

   p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !restart_i) |=> $stable(cnt_q));

   p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && $stable(last_idx_i)) |=> (cnt_q <= last_idx_i));

endmodule

// File: rtl/decim_mean_accum.sv
module decim_mean_accum #(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned SHIFT_W    = 5,
   parameter bit          ROUND_HALF = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     step_i,
   input  logic                     final_i,
   input  logic [SHIFT_W-1:0]       shift_i,
   input  logic signed [DATA_W-1:0] sample_i,
   output logic signed [DATA_W-1:0] mean_o
);

   if (ACC_W <= DATA_W) begin : g_bad
      $error("ACC_W must exceed DATA_W");
   end

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] sum_w;
   logic signed [ACC_W-1:0] biased_w;
   logic signed [ACC_W-1:0] scaled_w;

   assign sum_w = acc_q + ACC_W'(sample_i);

   if (ROUND_HALF) begin : g_round
      logic signed [ACC_W-1:0] half_w;
      always_comb begin
         if (shift_i == '0) half_w = '0;
         else               half_w = ACC_W'(1) <<< (shift_i - SHIFT_W'(1));
      end
      assign biased_w = sum_w + half_w;
   end else begin : g_floor
      assign biased_w = sum_w;
   end

   assign scaled_w = biased_w >>> shift_i;
   assign mean_o   = scaled_w[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         acc_q <= '0;
      end else if (step_i) begin
         if (final_i) acc_q <= '0;
         else         acc_q <= sum_w;
      end
   end

   p_acc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acc_q == '0));

   p_acc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && final_i && !clear_i) |=> (acc_q == '0));

   p_acc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clear_i) |=> $stable(acc_q));

endmodule

// File: rtl/decim_rate_reducer.sv
module decim_rate_reducer
   import decim_pkg::*;
#(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned FACTOR_W   = 17,
   parameter int unsigned ACC_W      = 32,
   parameter logic [FACTOR_W-1:0] LEGAL_MASK = DECIM_LEGAL_MASK_DEF,
   parameter bit          ROUND_HALF = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                factor_wr_i,
   input  logic [FACTOR_W-1:0] factor_i,
   input  logic                avg_en_i,
   input  logic                in_valid_i,
   input  logic [DATA_W-1:0]   in_data_i,
   output logic                out_valid_o,
   output logic [DATA_W-1:0]   out_data_o
);

   localparam int unsigned CNT_W   = FACTOR_W - 1;
   localparam int unsigned SHIFT_W = $clog2(FACTOR_W);

   if (ACC_W < DATA_W + CNT_W + 1) begin : g_bad_acc
      $error("ACC_W too narrow for the largest block sum");
   end

   logic [FACTOR_W-1:0] factor_q;
   logic [SHIFT_W-1:0]  shift_w;
   logic [CNT_W-1:0]    last_idx_w;
   logic                legal_w;
   logic                first_w;
   logic                final_w;
   logic                step_w;
   logic                emit_w;
   decim_mode_e         mode_w;
   logic signed [DATA_W-1:0] mean_w;
   logic [DATA_W-1:0]   pick_w;

   always_ff @(posedge clk) begin
      if (!rst_n)           factor_q <= FACTOR_W'(1);
      else if (factor_wr_i) factor_q <= factor_i;
   end

   decim_factor_decode #(
      .FACTOR_W   (FACTOR_W),
      .CNT_W      (CNT_W),
      .SHIFT_W    (SHIFT_W),
      .LEGAL_MASK (LEGAL_MASK)
   ) u_decode (
      .factor_i   (factor_q),
      .shift_o    (shift_w),
      .last_idx_o (last_idx_w),
      .legal_o    (legal_w)
   );

   assign step_w = in_valid_i && !factor_wr_i;
   assign mode_w = avg_en_i ? MODE_MEAN : MODE_PICK;

   decim_block_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (factor_wr_i),
      .step_i     (step_w),
      .last_idx_i (last_idx_w),
      .first_o    (first_w),
      .final_o    (final_w)
   );

   decim_mean_accum #(
      .DATA_W     (DATA_W),
      .ACC_W      (ACC_W),
      .SHIFT_W    (SHIFT_W),
      .ROUND_HALF (ROUND_HALF)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (factor_wr_i),
      .step_i   (step_w),
      .final_i  (final_w),
      .shift_i  (shift_w),
      .sample_i (in_data_i),
      .mean_o   (mean_w)
   );

   assign pick_w = in_data_i;
   assign emit_w = step_w && ((mode_w == MODE_MEAN) ? final_w : first_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
      end else begin
         out_valid_o <= emit_w;
         if (emit_w) begin
            out_data_o <= (mode_w == MODE_MEAN) ? mean_w : pick_w;
         end
      end
   end

   p_valid_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> ($past(in_valid_i) && !$past(factor_wr_i)));

   p_unit_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !factor_wr_i && factor_q == FACTOR_W'(1))
      |=> (out_valid_o && out_data_o == $past(in_data_i)));

   p_write_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      factor_wr_i |=> !out_valid_o);

   p_legal_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (factor_q == FACTOR_W'(1)) |-> legal_w);

endmodule

// File: tb/tb_decim_rate_reducer.sv
module tb_decim_rate_reducer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        factor_wr = 1'b0;
   logic [16:0] factor = '0;
   logic        avg_en = 1'b0;
   logic        in_valid = 1'b0;
   logic [13:0] in_data = '0;
   logic        out_valid;
   logic [13:0] out_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   decim_rate_reducer dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .factor_wr_i (factor_wr),
      .factor_i    (factor),
      .avg_en_i    (avg_en),
      .in_valid_i  (in_valid),
      .in_data_i   (in_data),
      .out_valid_o (out_valid),
      .out_data_o  (out_data)
   );

   function automatic int floor_mean(longint s, int n);
      longint q;
      q = s / n;
      if ((s % n) != 0 && s < 0) q = q - 1;
      return int'(q);
   endfunction

   task automatic check(input string req, input logic exp_v, input int exp_d);
      n_chk++;
      if (out_valid !== exp_v || (exp_v && int'($signed(out_data)) != exp_d)) begin
         n_err++;
         $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
                  req, out_valid, $signed(out_data), exp_v, exp_d);
      end
   endtask

   // Drive one cycle; outputs are sampled at the following falling edge
   task automatic push(input logic v, input int d, input string req,
                       input logic exp_v, input int exp_d);
      in_valid = v;
      in_data  = d[13:0];
      @(negedge clk);
      check(req, exp_v, exp_d);
      in_valid = 1'b0;
   endtask

   task automatic set_factor(input int f, input logic v, input int d);
      factor_wr = 1'b1;
      factor    = f[16:0];
      in_valid  = v;
      in_data   = d[13:0];
      @(negedge clk);
      check("R8 write cycle silent", 1'b0, 0);
      factor_wr = 1'b0;
      in_valid  = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 during reset", 1'b0, 0);
      n_chk++;
      if (out_data !== '0) begin
         n_err++;
         $display("FAIL R1: data=%0d expected 0", out_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 1'b0, 0);
      push(1'b1, 123, "R1 default factor 1", 1'b1, 123);
   endtask

   task automatic t_unit;
      avg_en = 1'b0;
      set_factor(1, 1'b0, 0);
      push(1'b1, -8192, "R3 pick min", 1'b1, -8192);
      push(1'b1, 8191, "R3 pick max", 1'b1, 8191);
      avg_en = 1'b1;
      push(1'b1, -5, "R3 mean neg", 1'b1, -5);
      push(1'b1, 77, "R3 mean pos", 1'b1, 77);
      push(1'b0, 99, "R7 idle at unit", 1'b0, 0);
   endtask

   task automatic t_pick;
      avg_en = 1'b0;
      set_factor(8, 1'b0, 0);
      for (int i = 0; i < 16; i++) begin
         if (i % 8 == 0) push(1'b1, i * 37 - 200, "R4 block head", 1'b1, i * 37 - 200);
         else            push(1'b1, i * 37 - 200, "R6 no extra output", 1'b0, 0);
      end
      set_factor(64, 1'b0, 0);
      for (int i = 0; i < 128; i++) begin
         if (i % 64 == 0) push(1'b1, 1000 - i, "R4 head at 64", 1'b1, 1000 - i);
         else             push(1'b1, 1000 - i, "R6 quiet at 64", 1'b0, 0);
      end
   endtask

   task automatic t_mean8;
      int vals[8] = '{100, -3, 7, 250, -8192, 8191, 1, -4};
      longint s;
      avg_en = 1'b1;
      set_factor(8, 1'b0, 0);
      s = 0;
      for (int i = 0; i < 8; i++) begin
         s += vals[i];
         if (i == 7) push(1'b1, vals[i], "R5 mean of 8", 1'b1, floor_mean(s, 8));
         else        push(1'b1, vals[i], "R6 quiet in block", 1'b0, 0);
      end
      for (int i = 0; i < 8; i++) begin
         if (i == 7) push(1'b1, 0, "R5 floor of -1/8", 1'b1, floor_mean(-1, 8));
         else        push(1'b1, (i == 0) ? -1 : 0, "R6 quiet in block", 1'b0, 0);
      end
   endtask

   task automatic t_gaps;
      longint s = 0;
      avg_en = 1'b1;
      set_factor(8, 1'b0, 0);
      for (int i = 0; i < 8; i++) begin
         s += i * 11;
         if (i == 7) push(1'b1, i * 11, "R7 mean across gaps", 1'b1, floor_mean(s, 8));
         else        push(1'b1, i * 11, "R7 quiet", 1'b0, 0);
         push(1'b0, 5000, "R7 idle ignored", 1'b0, 0);
      end
   endtask

   task automatic t_restart;
      avg_en = 1'b1;
      set_factor(8, 1'b0, 0);
      for (int i = 0; i < 3; i++) push(1'b1, 1000, "R8 partial block", 1'b0, 0);
      set_factor(8, 1'b1, 5000);
      for (int i = 0; i < 8; i++) begin
         if (i == 7) push(1'b1, 16, "R8 sum cleared", 1'b1, 16);
         else        push(1'b1, 16, "R8 quiet", 1'b0, 0);
      end
   endtask

   task automatic t_large;
      avg_en = 1'b1;
      set_factor(64, 1'b0, 0);
      for (int i = 0; i < 64; i++) begin
         if (i == 63) push(1'b1, i - 32, "R5 mean at 64", 1'b1, floor_mean(-32, 64));
         else         push(1'b1, i - 32, "R6 quiet at 64", 1'b0, 0);
      end
      set_factor(8192, 1'b0, 0);
      for (int i = 0; i < 8192; i++) begin
         if (i == 8191) push(1'b1, 8191, "R2 mean at 8192", 1'b1, 8191);
         else           push(1'b1, 8191, "R6 quiet at 8192", 1'b0, 0);
      end
      set_factor(65536, 1'b0, 0);
      for (int i = 0; i < 65536; i++) begin
         if (i == 65535) push(1'b1, -8192, "R9 full-scale sum", 1'b1, -8192);
         else            push(1'b1, -8192, "R6 quiet at 65536", 1'b0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_unit();
      t_pick();
      t_mean8();
      t_gaps();
      t_restart();
      t_large();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule